// File: doc/BRIEF.md
# Dual-Bank Piecewise-Linear Gamma Curve Stage

This block applies an output transfer curve to R, G and B pixel samples. The curve is piecewise linear. Each of the three channels has a table of points, and each point holds a base value and a slope delta. There are two complete tables, bank A and bank B. One bank can drive the pixel path while software fills the other through a single auto-incrementing data port. Software then switches the mode register to the freshly loaded bank, so a curve update never shows a half-written table.

The pixel input is 12 bits per channel. The upper bits pick the point and the lower eight bits are the fraction. The output is the base plus the delta scaled by the fraction, saturated to 12 bits. In bypass the sample passes through unchanged. The result appears two cycles after the input.

A loader state machine has three states. LD_IDLE is entered at reset, and data words are dropped there. LD_RUN is entered on `cfg_start` from any state and takes words. LD_FULL is entered from LD_RUN after the sixth word of the last point, and it drops words until the next `cfg_start`. A level input keeps the table memories powered. While that input is low the stage is forced to bypass and no word is taken.

Top module: `pwl_gamma_lut`

## Requirements
- R1: `status` reports the effective curve as 0 = bypass, 1 = bank A, 2 = bank B. A mode register value of 3 is reported as 0 and acts as bypass.
- R2: A cycle with `mode_wr` high loads `mode_val` into the mode register. The new mode applies to pixels sampled from the next cycle on. The mode resets to 0.
- R3: `next_bank` suggests the target of the next load. It is 1 (bank B) while `status` is 0 or 1, and 0 (bank A) while `status` is 2.
- R4: `cfg_start` moves the loader to LD_RUN from any state. It resets the point index and the word count to 0 and latches `cfg_bank` (0 = A, 1 = B) and `cfg_mask` (bit 0 = R, bit 1 = G, bit 2 = B). A data word in the same cycle is dropped.
- R5: Each point takes six words in this order: R base, G base, B base, R delta, G delta, B delta. A word for a channel whose mask bit is 0 is consumed but not stored.
- R6: The point index advances after the sixth word of a point. Words are dropped in LD_IDLE, which covers all words before the first `cfg_start`. Words are also dropped after the last point is complete (LD_FULL).
- R7: While `mem_keep_on` is low, `status` reads 0 and pixels pass in bypass. Data words are neither stored nor counted.
- R8: With bank X active, each channel outputs min(4095, base + ((delta × pix[7:0]) >> 8)), where base and delta are read from bank X at point pix[11:8]. Table entries reset to 0.
- R9: In bypass, each output equals its input sample.
- R10: `out_valid` follows `pix_valid` by exactly two cycles. `out_valid` and the outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_keep_on | input | 1 | Keeps the table memories powered; low forces bypass |
| mode_wr | input | 1 | Mode register write strobe |
| mode_val | input | 2 | Mode value: 0 bypass, 1 bank A, 2 bank B |
| cfg_start | input | 1 | Starts a table load |
| cfg_bank | input | 1 | Load target: 0 bank A, 1 bank B |
| cfg_mask | input | 3 | Channel write mask: bit 0 R, bit 1 G, bit 2 B |
| wr_valid | input | 1 | Data word strobe |
| wr_data | input | 12 | Data word |
| pix_valid | input | 1 | Pixel sample valid |
| pix_r | input | 12 | Red input sample |
| pix_g | input | 12 | Green input sample |
| pix_b | input | 12 | Blue input sample |
| out_valid | output | 1 | Output sample valid |
| out_r | output | 12 | Red output sample |
| out_g | output | 12 | Green output sample |
| out_b | output | 12 | Blue output sample |
| status | output | 2 | Effective curve: 0 bypass, 1 bank A, 2 bank B |
| next_bank | output | 1 | Suggested load target |

## Verification
A wrong point index or word count in the loader does not show up at once. It shows up only when a pixel reads the affected point in the bank that was loaded. The bench therefore sweeps every point of each bank two cycles after a load and compares every output against a model on every clock. A wrong mode or power decision shows up on `status` in the same cycle, and on the pixel outputs two cycles later. Masked channels, dropped words and early restarts all leave table contents that differ from the model, so a pixel that lands on the point involved reveals them.

// File: rtl/pwl_gamma_pkg.sv
package pwl_gamma_pkg;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_RUN  = 2'd1,
        LD_FULL = 2'd2
    } ld_state_e;

    localparam logic [1:0] CURVE_BYPASS = 2'd0;
    localparam logic [1:0] CURVE_BANK_A = 2'd1;
    localparam logic [1:0] CURVE_BANK_B = 2'd2;

    function automatic logic [1:0] effective_curve(input logic [1:0] mode, input logic powered);
        logic [1:0] r;
        if (!powered) begin
            r = CURVE_BYPASS;
        end else begin
            unique case (mode)
                CURVE_BANK_A: r = CURVE_BANK_A;
                CURVE_BANK_B: r = CURVE_BANK_B;
                default:      r = CURVE_BYPASS;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/lut_loader.sv
module lut_loader
    import pwl_gamma_pkg::*;
#(
    parameter int NPTS = 16,
    parameter int DW   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_start,
    input  logic                    cfg_bank,
    input  logic [2:0]              cfg_mask,
    input  logic                    pwr_on,
    input  logic                    wr_valid,
    input  logic [DW-1:0]           wr_data,
    output logic                    we_bank,
    output logic [2:0]              we_chan,
    output logic                    we_delta,
    output logic [$clog2(NPTS)-1:0] we_idx,
    output logic [DW-1:0]           we_data
);
    localparam int IW    = $clog2(NPTS);
    localparam int WORDS = 6;
    localparam logic [IW-1:0] LAST_IDX  = IW'(NPTS - 1);
    localparam logic [2:0]    LAST_WORD = 3'(WORDS - 1);

    ld_state_e      st_q, st_d;
    logic [IW-1:0]  idx_q, idx_d;
    logic [2:0]     wc_q, wc_d;
    logic           bank_q, bank_d;
    logic [2:0]     mask_q, mask_d;
    logic           accept;
    logic [2:0]     chan_sel;

    assign accept = (st_q == LD_RUN) && wr_valid && pwr_on && !cfg_start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LD_IDLE;
            idx_q  <= '0;
            wc_q   <= '0;
            bank_q <= 1'b0;
            mask_q <= '0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            wc_q   <= wc_d;
            bank_q <= bank_d;
            mask_q <= mask_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        idx_d  = idx_q;
        wc_d   = wc_q;
        bank_d = bank_q;
        mask_d = mask_q;
        if (cfg_start) begin
            st_d   = LD_RUN;
            idx_d  = '0;
            wc_d   = '0;
            bank_d = cfg_bank;
            mask_d = cfg_mask;
        end else begin
            unique case (st_q)
                LD_IDLE: ;
                LD_RUN: begin
                    if (accept) begin
                        if (wc_q == LAST_WORD) begin
                            wc_d = '0;
                            if (idx_q == LAST_IDX) st_d = LD_FULL;
                            else                   idx_d = idx_q + 1'b1;
                        end else begin
                            wc_d = wc_q + 1'b1;
                        end
                    end
                end
                LD_FULL: ;
                default: st_d = LD_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        we_delta = (wc_q >= 3'd3);
        chan_sel = we_delta ? (wc_q - 3'd3) : wc_q;
        for (int c = 0; c < 3; c++) begin
            we_chan[c] = accept && mask_q[c] && (chan_sel == 3'(c));
        end
        we_bank = bank_q;
        we_idx  = idx_q;
        we_data = wr_data;
    end

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LD_FULL) |-> (we_chan == 3'b000));

    // R7
    unpowered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on && !cfg_start) |=> ($stable(wc_q) && $stable(idx_q)));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> (idx_q == '0 && wc_q == '0 && st_q == LD_RUN));

endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
    parameter int NPTS = 16,
    parameter int DW   = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [2:0]                         we_chan,
    input  logic                               we_delta,
    input  logic [$clog2(NPTS)-1:0]            we_idx,
    input  logic [DW-1:0]                      we_data,
    input  logic [2:0][$clog2(NPTS)-1:0]       rd_idx,
    output logic [2:0][DW-1:0]                 rd_base,
    output logic [2:0][DW-1:0]                 rd_delta
);
    for (genvar c = 0; c < 3; c++) begin : g_ch
        logic [DW-1:0] base_m  [NPTS];
        logic [DW-1:0] delta_m [NPTS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < NPTS; i++) begin
                    base_m[i]  <= '0;
                    delta_m[i] <= '0;
                end
            end else if (we_chan[c]) begin
                if (we_delta) delta_m[we_idx] <= we_data;
                else          base_m[we_idx]  <= we_data;
            end
        end

        assign rd_base[c]  = base_m[rd_idx[c]];
        assign rd_delta[c] = delta_m[rd_idx[c]];
    end

endmodule

// File: rtl/pwl_interp.sv
module pwl_interp #(
    parameter int DW = 12,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byp,
    input  logic [DW-1:0] pix,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] delta,
    output logic [DW-1:0] y
);
    localparam logic [DW-1:0] SAT = {DW{1'b1}};

    logic          s_byp;
    logic [DW-1:0] s_pix, s_base, s_delta;
    logic [FW-1:0] s_frac;
    logic [DW+FW:0] acc;
    logic [DW:0]    sum;
    logic           unused_lsb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_byp   <= 1'b1;
            s_pix   <= '0;
            s_base  <= '0;
            s_delta <= '0;
            s_frac  <= '0;
        end else begin
            s_byp   <= byp;
            s_pix   <= pix;
            s_base  <= base;
            s_delta <= delta;
            s_frac  <= pix[FW-1:0];
        end
    end

    always_comb begin
        acc = {1'b0, s_base, {FW{1'b0}}} + (DW+FW+1)'(s_delta * s_frac);
        sum = acc[DW+FW:FW];
        unused_lsb = ^acc[FW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      y <= '0;
        else if (s_byp)  y <= s_pix;
        else if (sum[DW]) y <= SAT;
        else             y <= sum[DW-1:0];
    end

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_byp |=> (y >= $past(s_base)));

    // R9
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_byp |=> (y == $past(s_pix)));

endmodule

// File: rtl/pwl_gamma_lut.sv
module pwl_gamma_lut
    import pwl_gamma_pkg::*;
#(
    parameter int DW = 12,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_keep_on,
    input  logic          mode_wr,
    input  logic [1:0]    mode_val,
    input  logic          cfg_start,
    input  logic          cfg_bank,
    input  logic [2:0]    cfg_mask,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          pix_valid,
    input  logic [DW-1:0] pix_r,
    input  logic [DW-1:0] pix_g,
    input  logic [DW-1:0] pix_b,
    output logic          out_valid,
    output logic [DW-1:0] out_r,
    output logic [DW-1:0] out_g,
    output logic [DW-1:0] out_b,
    output logic [1:0]    status,
    output logic          next_bank
);
    localparam int IW   = DW - FW;
    localparam int NPTS = 1 << IW;

    logic [1:0]            mode_q;
    logic                  s1_v;
    logic                  we_bank, we_delta;
    logic [2:0]            we_chan;
    logic [IW-1:0]         we_idx;
    logic [DW-1:0]         we_data;
    logic [2:0][DW-1:0]    pix_in, y_out, sel_base, sel_delta;
    logic [2:0][IW-1:0]    rd_idx;
    logic [2:0][DW-1:0]    bk_base  [2];
    logic [2:0][DW-1:0]    bk_delta [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= CURVE_BYPASS;
        else if (mode_wr) mode_q <= mode_val;
    end

    assign status    = effective_curve(mode_q, mem_keep_on);
    assign next_bank = (status != CURVE_BANK_B);

    lut_loader #(.NPTS(NPTS), .DW(DW)) u_loader (
        .clk(clk), .rst_n(rst_n),
        .cfg_start(cfg_start), .cfg_bank(cfg_bank), .cfg_mask(cfg_mask),
        .pwr_on(mem_keep_on), .wr_valid(wr_valid), .wr_data(wr_data),
        .we_bank(we_bank), .we_chan(we_chan), .we_delta(we_delta),
        .we_idx(we_idx), .we_data(we_data)
    );

    assign pix_in[0] = pix_r;
    assign pix_in[1] = pix_g;
    assign pix_in[2] = pix_b;

    for (genvar c = 0; c < 3; c++) begin : g_idx
        assign rd_idx[c] = pix_in[c][DW-1:FW];
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        lut_bank #(.NPTS(NPTS), .DW(DW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we_chan(we_chan & {3{we_bank == 1'(b)}}),
            .we_delta(we_delta), .we_idx(we_idx), .we_data(we_data),
            .rd_idx(rd_idx), .rd_base(bk_base[b]), .rd_delta(bk_delta[b])
        );
    end

    assign sel_base  = (status == CURVE_BANK_B) ? bk_base[1]  : bk_base[0];
    assign sel_delta = (status == CURVE_BANK_B) ? bk_delta[1] : bk_delta[0];

    for (genvar c = 0; c < 3; c++) begin : g_interp
        pwl_interp #(.DW(DW), .FW(FW)) u_interp (
            .clk(clk), .rst_n(rst_n),
            .byp(status == CURVE_BYPASS), .pix(pix_in[c]),
            .base(sel_base[c]), .delta(sel_delta[c]), .y(y_out[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_v      <= pix_valid;
            out_valid <= s1_v;
        end
    end

    assign out_r = y_out[0];
    assign out_g = y_out[1];
    assign out_b = y_out[2];

    // R1
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);

    // R7
    unpowered_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_keep_on |-> (status == CURVE_BYPASS));

    // R10
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_v |=> !out_valid);

endmodule

// File: tb/pwl_gamma_lut_tb.sv
module pwl_gamma_lut_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_keep_on = 1'b0, mode_wr = 1'b0, cfg_start = 1'b0, cfg_bank = 1'b0;
    logic [1:0]  mode_val = 2'd0;
    logic [2:0]  cfg_mask = 3'd0;
    logic        wr_valid = 1'b0, pix_valid = 1'b0;
    logic [11:0] wr_data = '0, pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid, next_bank;
    logic [11:0] out_r, out_g, out_b;
    logic [1:0]  status;

    int checks = 0, errors = 0;
    bit done = 0;

    pwl_gamma_lut u_dut (
        .clk(clk), .rst_n(rst_n), .mem_keep_on(mem_keep_on), .mode_wr(mode_wr),
        .mode_val(mode_val), .cfg_start(cfg_start), .cfg_bank(cfg_bank),
        .cfg_mask(cfg_mask), .wr_valid(wr_valid), .wr_data(wr_data),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .status(status), .next_bank(next_bank)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    int mb [2][3][16];
    int md [2][3][16];
    int ld_st, ld_idx, ld_wc, ld_bank, ld_mask, mode_m;
    int e1v, e2v;
    int e1 [3];
    int e2 [3];

    function automatic int curve(int m, bit pw);
        if (!pw) return 0;
        if (m == 1 || m == 2) return m;
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 3; c++)
                    for (int i = 0; i < 16; i++) begin
                        mb[b][c][i] = 0;
                        md[b][c][i] = 0;
                    end
            ld_st = 0; ld_idx = 0; ld_wc = 0; ld_bank = 0; ld_mask = 0; mode_m = 0;
            e1v = 0; e2v = 0;
            for (int c = 0; c < 3; c++) begin e1[c] = 0; e2[c] = 0; end
        end else begin
            int cv;
            int px [3];
            px[0] = pix_r; px[1] = pix_g; px[2] = pix_b;
            cv = curve(mode_m, mem_keep_on);
            e2v = e1v;
            for (int c = 0; c < 3; c++) e2[c] = e1[c];
            e1v = pix_valid;
            for (int c = 0; c < 3; c++) begin
                if (cv == 0) e1[c] = px[c];
                else begin
                    int seg, fr, v;
                    seg = px[c] / 256;
                    fr  = px[c] % 256;
                    v = mb[cv-1][c][seg] + (md[cv-1][c][seg] * fr) / 256;
                    e1[c] = (v > 4095) ? 4095 : v;
                end
            end
            if (cfg_start) begin
                ld_st = 1; ld_idx = 0; ld_wc = 0; ld_bank = cfg_bank; ld_mask = cfg_mask;
            end else if (ld_st == 1 && wr_valid && mem_keep_on) begin
                int ch;
                ch = ld_wc % 3;
                if (ld_mask[ch]) begin
                    if (ld_wc < 3) mb[ld_bank][ch][ld_idx] = wr_data;
                    else           md[ld_bank][ch][ld_idx] = wr_data;
                end
                if (ld_wc == 5) begin
                    ld_wc = 0;
                    if (ld_idx == 15) ld_st = 2;
                    else ld_idx++;
                end else ld_wc++;
            end
            if (mode_wr) mode_m = mode_val;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 out_valid", out_valid, e2v);
            if (e2v) begin
                chk("R5 R8 R9 out_r", out_r, e2[0]);
                chk("R5 R8 R9 out_g", out_g, e2[1]);
                chk("R5 R8 R9 out_b", out_b, e2[2]);
            end
            chk("R1 R2 R7 status", status, curve(mode_m, mem_keep_on));
            chk("R3 next_bank", next_bank, (curve(mode_m, mem_keep_on) == 2) ? 0 : 1);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
        mode_wr = 0; cfg_start = 0; wr_valid = 0; pix_valid = 0;
    endtask

    task automatic set_mode(int m);
        mode_wr = 1; mode_val = 2'(m); tick();
    endtask

    task automatic cfg(int b, int m);
        cfg_start = 1; cfg_bank = 1'(b); cfg_mask = 3'(m); tick();
    endtask

    task automatic word(int d);
        wr_valid = 1; wr_data = 12'(d); tick();
    endtask

    task automatic pixel(int r, int g, int b);
        pix_valid = 1; pix_r = 12'(r); pix_g = 12'(g); pix_b = 12'(b); tick();
    endtask

    // sends one pixel and returns after the result has appeared
    task automatic probe(int r, int g, int b);
        pixel(r, g, b); tick(); tick();
    endtask

    task automatic sweep(int seed);
        for (int k = 0; k < 48; k++)
            pixel((k * 373 + seed) % 4096, (k * 1021 + seed * 3) % 4096, (k * 87 + 4095 - seed) % 4096);
        tick(); tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        chk("R10 reset out_valid", out_valid, 0);
        chk("R10 reset out_r", out_r, 0);
        chk("R2 reset status", status, 0);
        rst_n = 1;
        tick();
        mem_keep_on = 1;
        // R6: words before any load configuration are dropped
        for (int k = 0; k < 6; k++) word(999);
        // load bank A with all channels
        cfg(0, 7);
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < 3; c++) word(i * 250 + c * 20);
            for (int c = 0; c < 3; c++) word(40 + i * 3 + c * 5);
        end
        // R6: words after the last point are dropped
        for (int k = 0; k < 12; k++) word(7);
        chk("R3 next_bank bypass", next_bank, 1);
        set_mode(1);
        chk("R2 status bank A", status, 1);
        chk("R3 next_bank A", next_bank, 1);
        probe(12'hF80, 12'h040, 12'h000);
        chk("R6 R8 last point r", out_r, 3792);
        chk("R6 first point g", out_g, 20 + (45 * 64) / 256);
        sweep(11);
        // load bank B with the green channel masked
        cfg(1, 5);
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < 3; c++) word(i == 15 ? 4000 : 3000 - i * 100 + c);
            for (int c = 0; c < 3; c++) word(i == 15 ? 4000 : 500);
        end
        sweep(200);
        set_mode(2);
        chk("R3 next_bank B", next_bank, 0);
        probe(12'hFFF, 12'hFFF, 12'hF00);
        chk("R8 saturation r", out_r, 4095);
        chk("R5 masked g", out_g, 0);
        chk("R8 base only b", out_b, 4000);
        sweep(57);
        // R4: restart mid-point
        cfg(1, 7);
        word(9); word(9); word(9);
        cfg(1, 7);
        word(100); word(200); word(300); word(256); word(256); word(256);
        probe(12'h080, 12'h080, 12'h080);
        chk("R4 restart r", out_r, 228);
        chk("R4 restart b", out_b, 428);
        // R7: unpowered stage
        cfg(1, 7);
        mem_keep_on = 0;
        tick();
        chk("R7 status off", status, 0);
        for (int k = 0; k < 6; k++) word(55);
        probe(12'h123, 12'h456, 12'h789);
        chk("R7 R9 bypass r", out_r, 12'h123);
        mem_keep_on = 1;
        for (int k = 0; k < 3; k++) word(500);
        for (int k = 0; k < 3; k++) word(0);
        probe(12'h080, 12'h0FF, 12'h000);
        chk("R7 words not consumed r", out_r, 500);
        // R1: code 3 acts as bypass
        set_mode(3);
        chk("R1 code3 status", status, 0);
        probe(12'hABC, 12'h001, 12'hFFF);
        chk("R1 R9 code3 bypass g", out_g, 1);
        sweep(5);
        set_mode(1);
        sweep(300);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule